// File: doc/BRIEF.md
# Pulse-to-Oscillator Phase Interval Meter

The block measures how far a disciplined oscillator lags a once-per-second timing pulse. The oscillator is first divided by a selectable power of two. A gate opens on the rising edge of the timing pulse and closes on the next rising edge of the divided oscillator. While the gate is open, the block counts cycles of a free-running reference clock (about 24 MHz, so one count is roughly 42 ns). That clock is deliberately not locked to the oscillator. Its slow drift therefore spreads the one-count quantisation error, and summing many intervals resolves phase more finely than one count.

The lengths of a fixed number of gated intervals (30 by default) are added into one reading. At the end of that window the total and its overflow flag are copied into a parallel-in, serial-out register, a ready flag is raised, and the accumulator starts again from zero. A host reads the reading one bit at a time, most significant bit first, by toggling a shift clock.

The oscillator input, the timing pulse and the shift clock are all sampled in the reference clock domain through two-flop synchronisers. If no timing pulse arrives within a timeout (1.5 s of reference clock by default), the block raises a missing-pulse flag. It also forces an open gate shut, so the broken interval never reaches the sum.

Top module: `gps_phase_meter`

## Requirements
- R1: During and right after reset, `rdy_o`, `sdo_o`, `ovf_o` and `miss_o` are all 0.
- R2: With `div_sel_i` = s (0 gives divide by 2, 1 by 4, 2 by 8, 3 by 16), the divided oscillator rises on the oscillator rising edge that brings the number of rising edges since reset to n, where n mod 2^(s+1) equals 2^s.
- R3: The length of an interval is the number of reference clock cycles from the timing pulse rising edge to the next divided rising edge. Both inputs pass through equal synchroniser delays. A divided edge in the same cycle as the pulse edge, or before it, does not close the gate.
- R4: A timing pulse rising edge that arrives while the gate is already open is ignored. It neither restarts nor lengthens the interval.
- R5: The lengths of WINDOW completed intervals (default 30) are summed into one reading, and the accumulator then restarts from zero.
- R6: The sum saturates at 2^ACC_W-1 (ACC_W defaults to 16). `ovf_o` is 1 for a reading if any addition in its window went beyond that value, and 0 otherwise.
- R7: When a reading completes, `rdy_o` rises and `sdo_o` presents the reading's most significant bit.
- R8: Each rising edge of `sclk_i` shifts the register by one place, so the bits come out most significant first. The first shift after a reading clears `rdy_o`.
- R9: `miss_o` goes to 1 after TIMEOUT reference cycles pass with no timing pulse rising edge, and goes back to 0 on the next rising edge.
- R10: When the timeout expires with the gate open, the gate shuts, and that interval neither adds to the sum nor counts toward the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock; every register in the block runs on it |
| rst_i | input | 1 | Synchronous active-high reset |
| osc_i | input | 1 | Oscillator being disciplined, asynchronous |
| pps_i | input | 1 | Once-per-second timing pulse, asynchronous |
| div_sel_i | input | 2 | Prescale select: the divide ratio is 2^(value+1) |
| sclk_i | input | 1 | Host shift clock, asynchronous |
| sdo_o | output | 1 | Serial reading data, most significant bit first |
| rdy_o | output | 1 | A new reading is waiting |
| ovf_o | output | 1 | The latched reading saturated |
| miss_o | output | 1 | The timing pulse has been absent for longer than TIMEOUT |

## Verification
The assertions check, on every cycle:
- the gate opens only on a detected pulse edge;
- an interval finishes only from an open gate;
- a missing-pulse timeout always leaves the gate shut;
- a saturated reading is latched at full scale;
- the ready flag follows loads and shifts;
- the serial output holds still between shifts.

Only the bench's scenarios can show that the interval lengths, the window sums and the prescaler phase are numerically right. Its scenarios cover each divide ratio used with randomly spaced pulses, double pulses inside an open gate, a saturating window, and an interval discarded after the oscillator stops.

// File: rtl/gps_phase_meter_pkg.sv
package gps_phase_meter_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;
endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int DIV_W = 4,
  localparam int SEL_W = $clog2(DIV_W)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             osc_rise_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;

  assign cnt_nxt    = cnt_q + 1'b1;
  assign div_rise_o = osc_rise_i & ~cnt_q[sel_i] & cnt_nxt[sel_i];

  always_ff @(posedge clk_i) begin
    if (rst_i)           cnt_q <= '0;
    else if (osc_rise_i) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pm_gate.sv
module pm_gate
  import gps_phase_meter_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int TIMEOUT = 36_000_000,
  localparam int TMO_W  = $clog2(TIMEOUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             pps_rise_i,
  input  logic             div_rise_i,
  output logic             gate_open_o,
  output logic             done_o,
  output logic [ACC_W-1:0] len_o,
  output logic             miss_o
);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);
  localparam logic [TMO_W-1:0] TMO_END  = TMO_W'(TIMEOUT);

  gate_e            gate_q;
  logic [ACC_W-1:0] run_q;
  logic [TMO_W-1:0] tmo_q;
  logic             expire;

  assign expire      = ~pps_rise_i & (tmo_q == TMO_LAST);
  assign gate_open_o = (gate_q == GATE_OPEN);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gate_q <= GATE_SHUT;
      run_q  <= '0;
      tmo_q  <= '0;
      miss_o <= 1'b0;
      done_o <= 1'b0;
      len_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (pps_rise_i) begin
        tmo_q  <= '0;
        miss_o <= 1'b0;
      end else if (tmo_q != TMO_END) begin
        tmo_q <= tmo_q + 1'b1;
        if (expire) miss_o <= 1'b1;
      end
      case (gate_q)
        GATE_SHUT: begin
          if (pps_rise_i) begin
            gate_q <= GATE_OPEN;
            run_q  <= '0;
          end
        end
        GATE_OPEN: begin
          if (expire) begin
            gate_q <= GATE_SHUT;
          end else if (div_rise_i) begin
            gate_q <= GATE_SHUT;
            done_o <= 1'b1;
            len_o  <= (&run_q) ? run_q : run_q + 1'b1;
          end else if (!(&run_q)) begin
            run_q <= run_q + 1'b1;
          end
        end
        default: gate_q <= GATE_SHUT;
      endcase
    end
  end
endmodule

// File: rtl/pm_window.sv
module pm_window #(
  parameter int ACC_W  = 16,
  parameter int WINDOW = 30,
  localparam int NW    = $clog2(WINDOW)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             done_i,
  input  logic [ACC_W-1:0] len_i,
  output logic             win_v_o,
  output logic [ACC_W-1:0] win_total_o,
  output logic             win_ovf_o
);
  localparam logic [NW-1:0] LAST = NW'(WINDOW - 1);

  logic [ACC_W-1:0] acc_q;
  logic             sticky_q;
  logic [NW-1:0]    nint_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] sat;

  assign sum = {1'b0, acc_q} + {1'b0, len_i};
  assign sat = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q       <= '0;
      sticky_q    <= 1'b0;
      nint_q      <= '0;
      win_v_o     <= 1'b0;
      win_total_o <= '0;
      win_ovf_o   <= 1'b0;
    end else begin
      win_v_o <= 1'b0;
      if (done_i) begin
        if (nint_q == LAST) begin
          win_v_o     <= 1'b1;
          win_total_o <= sat;
          win_ovf_o   <= sticky_q | sum[ACC_W];
          acc_q       <= '0;
          sticky_q    <= 1'b0;
          nint_q      <= '0;
        end else begin
          acc_q    <= sat;
          sticky_q <= sticky_q | sum[ACC_W];
          nint_q   <= nint_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pm_piso.sv
module pm_piso #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] data_i,
  input  logic             ovf_i,
  input  logic             shift_i,
  output logic             sdo_o,
  output logic             rdy_o,
  output logic             ovf_o
);
  logic [ACC_W-1:0] sr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sr_q  <= '0;
      rdy_o <= 1'b0;
      ovf_o <= 1'b0;
    end else if (load_i) begin
      sr_q  <= data_i;
      rdy_o <= 1'b1;
      ovf_o <= ovf_i;
    end else if (shift_i) begin
      sr_q  <= {sr_q[ACC_W-2:0], 1'b0};
      rdy_o <= 1'b0;
    end
  end

  assign sdo_o = sr_q[ACC_W-1];
endmodule

// File: rtl/gps_phase_meter.sv
module gps_phase_meter #(
  parameter int ACC_W       = 16,
  parameter int WINDOW      = 30,
  parameter int TIMEOUT     = 36_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 4,
  localparam int SEL_W      = $clog2(DIV_W)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             osc_i,
  input  logic             pps_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             sclk_i,
  output logic             sdo_o,
  output logic             rdy_o,
  output logic             ovf_o,
  output logic             miss_o
);
  localparam int N_IN = 3;

  logic [N_IN-1:0]  raw_in;
  logic [N_IN-1:0]  rise;
  logic             osc_rise, pps_rise, sclk_rise, div_rise;
  logic             gate_open, iv_done;
  logic [ACC_W-1:0] iv_len;
  logic             win_v, win_ovf;
  logic [ACC_W-1:0] win_total;

  assign raw_in = {sclk_i, pps_i, osc_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    pm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i(clk_i), .rst_i(rst_i), .d_i(raw_in[g]), .rise_o(rise[g])
    );
  end

  assign osc_rise  = rise[0];
  assign pps_rise  = rise[1];
  assign sclk_rise = rise[2];

  pm_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk_i(clk_i), .rst_i(rst_i), .osc_rise_i(osc_rise),
    .sel_i(div_sel_i), .div_rise_o(div_rise)
  );

  pm_gate #(.ACC_W(ACC_W), .TIMEOUT(TIMEOUT)) gate_i (
    .clk_i(clk_i), .rst_i(rst_i), .pps_rise_i(pps_rise), .div_rise_i(div_rise),
    .gate_open_o(gate_open), .done_o(iv_done), .len_o(iv_len), .miss_o(miss_o)
  );

  pm_window #(.ACC_W(ACC_W), .WINDOW(WINDOW)) win_i (
    .clk_i(clk_i), .rst_i(rst_i), .done_i(iv_done), .len_i(iv_len),
    .win_v_o(win_v), .win_total_o(win_total), .win_ovf_o(win_ovf)
  );

  pm_piso #(.ACC_W(ACC_W)) piso_i (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(win_v), .data_i(win_total),
    .ovf_i(win_ovf), .shift_i(sclk_rise), .sdo_o(sdo_o), .rdy_o(rdy_o),
    .ovf_o(ovf_o)
  );
endmodule

// File: rtl/gps_phase_meter_chk.sv
module gps_phase_meter_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             pps_rise,
  input logic             sclk_rise,
  input logic             gate_open,
  input logic             iv_done,
  input logic             win_v,
  input logic             win_ovf,
  input logic [ACC_W-1:0] win_total,
  input logic             rdy_o,
  input logic             sdo_o,
  input logic             miss_o
);
  AST_GATE_OPENS_ON_PPS: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(gate_open) |-> $past(pps_rise)); // R3
  AST_DONE_FROM_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
    iv_done |-> $past(gate_open)); // R5
  AST_SAT_FULL_SCALE: assert property (@(posedge clk_i) disable iff (rst_i)
    (win_v && win_ovf) |-> (&win_total)); // R6
  AST_RDY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    win_v |=> rdy_o); // R7
  AST_SHIFT_DROPS_RDY: assert property (@(posedge clk_i) disable iff (rst_i)
    (sclk_rise && !win_v) |=> !rdy_o); // R8
  AST_SDO_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sclk_rise && !win_v) |=> $stable(sdo_o)); // R8
  AST_MISS_SHUTS_GATE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(miss_o) |-> !gate_open); // R10
  AST_MISS_CLEARS_ON_PPS: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(miss_o) |-> $past(pps_rise)); // R9
endmodule

bind gps_phase_meter gps_phase_meter_chk #(.ACC_W(ACC_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .pps_rise(pps_rise), .sclk_rise(sclk_rise),
  .gate_open(gate_open), .iv_done(iv_done), .win_v(win_v), .win_ovf(win_ovf),
  .win_total(win_total), .rdy_o(rdy_o), .sdo_o(sdo_o), .miss_o(miss_o)
);

// File: tb/gps_phase_meter_tb_top.sv
module gps_phase_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 9;
  localparam int WIN        = 8;
  localparam int TMO        = 600;
  localparam int MAXV       = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc = 1'b0, pps = 1'b0, sclk = 1'b0;
  logic [1:0] sel = 2'd0;
  logic sdo, rdy, ovf, miss;

  int total = 0, bad = 0;

  // stimulus controls written by the main process
  int osc_p = 5, gap_lo = 150, gap_hi = 250;
  bit run_osc = 1'b1, pps_en = 1'b1, dbl = 1'b0, fire_req = 1'b0;

  // driver and reference model state
  int cyc, osc_ph, pps_hi, next_pps, dbl_at, osc_n, gstart, last_pps, nint, sum;
  bit gate_m, ov_m;
  int exp_v[32];
  bit exp_o[32];
  int ne;

  always #(CLK_PERIOD/2) clk = ~clk;

  gps_phase_meter #(.ACC_W(ACC_W), .WINDOW(WIN), .TIMEOUT(TMO)) dut_i (
    .clk_i(clk), .rst_i(rst), .osc_i(osc), .pps_i(pps), .div_sel_i(sel),
    .sclk_i(sclk), .sdo_o(sdo), .rdy_o(rdy), .ovf_o(ovf), .miss_o(miss)
  );

  function automatic int sat_len(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic account(int len);
    int t;
    t = sum + sat_len(len);
    if (t > MAXV) begin ov_m = 1'b1; sum = MAXV; end
    else sum = t;
    nint++;
    if (nint == WIN) begin
      exp_v[ne % 32] = sum; exp_o[ne % 32] = ov_m; ne++;
      nint = 0; sum = 0; ov_m = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    bit n_osc, n_pps, o_r, p_r, d_r, was_open;
    if (rst) begin
      cyc = 0; osc_ph = 0; pps_hi = 0; next_pps = gap_lo; dbl_at = -1;
      osc_n = 0; gstart = 0; last_pps = 0; nint = 0; sum = 0;
      gate_m = 1'b0; ov_m = 1'b0; ne = 0; osc = 1'b0; pps = 1'b0;
    end else begin
      cyc++;
      if (run_osc) begin osc_ph = (osc_ph + 1) % osc_p; n_osc = (osc_ph >= osc_p / 2); end
      else begin osc_ph = 0; n_osc = 1'b0; end
      if (!pps_en) next_pps = cyc + gap_lo;
      else if (cyc == next_pps) begin
        pps_hi = 3;
        if (dbl) dbl_at = cyc + 12;
        next_pps = cyc + gap_lo + int'($urandom % (gap_hi - gap_lo + 1));
      end
      if (cyc == dbl_at) pps_hi = 3;
      if (fire_req) begin pps_hi = 3; fire_req = 1'b0; end
      n_pps = (pps_hi > 0);
      if (pps_hi > 0) pps_hi--;
      o_r = n_osc && !osc; p_r = n_pps && !pps;
      osc = n_osc; pps = n_pps;
      d_r = 1'b0;
      if (o_r) begin
        osc_n++;
        d_r = ((osc_n % (2 << sel)) == (1 << sel));  // R2 phase of divided edge
      end
      was_open = gate_m;
      if (was_open) begin
        if (!p_r && (cyc - last_pps == TMO)) gate_m = 1'b0;   // R10 discard
        else if (d_r) begin gate_m = 1'b0; account(cyc - gstart); end
      end else if (p_r) begin
        gate_m = 1'b1; gstart = cyc;                          // R4 only when shut
      end
      if (p_r) last_pps = cyc;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset(logic [1:0] s);
    rst = 1'b1; sel = s;
    repeat (6) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_one(int idx, string req);
    int val;
    bit ov;
    while (!rdy) @(negedge clk);
    ov = ovf; val = 0;
    for (int i = 0; i < ACC_W; i++) begin
      val = (val << 1) | int'(sdo);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      if (i == 0) check(rdy == 1'b0, "R8 rdy after first shift", int'(rdy), 0);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    check(idx < ne, "R5 reading present in model", ne, idx + 1);
    check(val == exp_v[idx % 32], req, val, exp_v[idx % 32]);
    check(ov == exp_o[idx % 32], "R6 overflow flag", int'(ov), int'(exp_o[idx % 32]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    do_reset(2'd0);
    @(negedge clk);
    check(rdy == 1'b0, "R1 rdy_o after reset", int'(rdy), 0);
    check(sdo == 1'b0, "R1 sdo_o after reset", int'(sdo), 0);
    check(ovf == 1'b0, "R1 ovf_o after reset", int'(ovf), 0);
    check(miss == 1'b0, "R1 miss_o after reset", int'(miss), 0);

    // divide by 2, random pulse spacing: R2 R3 R5 R7
    for (int k = 0; k < 3; k++) read_one(k, "R2/R3/R5/R7 sum div2");

    // divide by 8 with a second pulse inside the open gate: R4
    osc_p = 6; gap_lo = 200; gap_hi = 350; dbl = 1'b1;
    do_reset(2'd2);
    for (int k = 0; k < 2; k++) read_one(k, "R4/R5 sum div8 double pulse");
    dbl = 1'b0;

    // divide by 16 with long intervals: R6 saturation
    osc_p = 13; gap_lo = 300; gap_hi = 420;
    do_reset(2'd3);
    for (int k = 0; k < 2; k++) read_one(k, "R6 saturated sum div16");

    // timeout scenario: R9 R10
    osc_p = 5; gap_lo = 150; gap_hi = 250;
    do_reset(2'd1);
    read_one(0, "R2/R5 sum div4");
    check(miss == 1'b0, "R9 no miss with regular pulses", int'(miss), 0);
    pps_en = 1'b0; run_osc = 1'b0;
    repeat (300) @(negedge clk);
    fire_req = 1'b1;
    repeat (10) @(negedge clk);
    check(miss == 1'b0, "R9 miss low right after pulse", int'(miss), 0);
    repeat (TMO + 40) @(negedge clk);
    check(miss == 1'b1, "R9 miss after timeout", int'(miss), 1);
    run_osc = 1'b1; pps_en = 1'b1;
    repeat (gap_lo + 20) @(negedge clk);
    check(miss == 1'b0, "R9 miss cleared by next pulse", int'(miss), 0);
    read_one(1, "R10 discarded interval excluded");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule